// File: doc/BRIEF.md
# Branch Condition Evaluator

This block decides, within the same cycle, whether a relative branch instruction is taken and which address the program counter moves to next. It sees the 8-bit opcode, six status flags and the address of the instruction that follows the branch. It also sees the signed 8-bit displacement byte and the level of an external active-low interrupt pin. From these it produces a taken flag, the next program counter, and an illegal flag for any opcode it does not handle.

Two opcode rows are decoded. Row 0x2 holds eight flag conditions selected by opcode bits [3:1]. Row 0x9 holds the two signed-compare conditions. In both rows, opcode bit 0 inverts the selected condition, which gives the complementary branch of each pair. The interrupt pin goes through a small synchronizer before the pin condition uses it. Everything else is combinational, so the instruction sequencer around the block can use the result in the cycle it presents the operands.

Top module: `branch_cond_eval`

## Requirements
- R1: For opcodes 0x20–0x2F with bit 0 clear, bits [3:1] select the condition. 0 is always true. 1 is C=0 and Z=0. 2 is C=0. 3 is Z=0. 4 is H=0. 5 is N=0. 6 is I=0. 7 is interrupt pin asserted. `taken` equals that condition.
- R2: Opcode 0x90 is taken when N equals V. Opcode 0x92 is taken when Z=0 and N equals V.
- R3: An opcode with bit 0 set, in either valid row, is taken exactly when its even partner would not be. Opcode 0x21 is therefore never taken.
- R4: Any opcode outside 0x20–0x2F and 0x90–0x93 raises `illegal`, gives `taken`=0, and gives `target_pc`=`next_addr`.
- R5: When taken, `target_pc` equals `next_addr` plus the sign-extended displacement, modulo 2^16. For example, 0xFFFF+0x01 gives 0x0000 and 0x0000+0x80 gives 0xFF80.
- R6: When not taken, `target_pc` equals `next_addr`, because the displacement byte has already been consumed.
- R7: The pin condition uses `irq_pin_n` after a two-flop synchronizer. The pin counts as asserted when the synchronized level is low. A new level becomes visible after the second rising clock edge. While reset is applied, the synchronizer holds the deasserted (high) level.
- R8: `taken`, `target_pc` and `illegal` follow opcode, flags, address and displacement with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the pin synchronizer |
| rst_n | input | 1 | Active-low asynchronous reset |
| opcode | input | 8 | Branch opcode under evaluation |
| flag_c | input | 1 | Carry flag |
| flag_z | input | 1 | Zero flag |
| flag_n | input | 1 | Negative flag |
| flag_v | input | 1 | Overflow flag |
| flag_h | input | 1 | Half-carry flag |
| flag_i | input | 1 | Interrupt mask flag |
| irq_pin_n | input | 1 | External interrupt pin level, low means asserted |
| next_addr | input | 16 | Address of the instruction after the branch |
| disp | input | 8 | Signed branch displacement |
| taken | output | 1 | Branch is taken |
| target_pc | output | 16 | Next program counter |
| illegal | output | 1 | Opcode is not a supported branch |

## Verification
The bound assertions check the following on every clock edge:
- an illegal opcode never branches and never moves the counter;
- a not-taken result keeps the fall-through address;
- a taken result lands on the sign-extended sum;
- the unconditional pair and the first signed-compare branch follow their conditions;
- the synchronized pin, held low for two edges, makes the pin branch taken.

Only the bench shows certain behaviours. Odd opcodes must be the exact complement of their even partners over all 64 flag combinations. The address sum must wrap at both ends of the range. The pin must take exactly two edges to reach the condition and stay idle while reset is applied. Outputs must respond to the flags with no edge in between.

// File: rtl/bce_pkg.sv
package bce_pkg;

    typedef struct packed {
        logic c;
        logic z;
        logic n;
        logic v;
        logic h;
        logic i;
    } bce_flags_t;

    typedef enum logic [2:0] {
        SEL_ALWAYS   = 3'd0,
        SEL_ABOVE    = 3'd1,
        SEL_NOCARRY  = 3'd2,
        SEL_NONZERO  = 3'd3,
        SEL_NOHALF   = 3'd4,
        SEL_POSITIVE = 3'd5,
        SEL_UNMASKED = 3'd6,
        SEL_PINLOW   = 3'd7
    } bce_sel_t;

    typedef enum logic [1:0] {
        ROW_PLAIN  = 2'd0,
        ROW_SIGNED = 2'd1,
        ROW_NONE   = 2'd2
    } bce_row_t;

    typedef struct packed {
        bce_row_t row;
        bce_sel_t sel;
        logic     invert;
        logic     illegal;
    } bce_decode_t;

endpackage

// File: rtl/bce_pin_sync.sv
module bce_pin_sync #(
    parameter int  STAGES     = 2,
    parameter logic IDLE_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    output logic pin_sync
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_state_t;

    sync_state_t st_d, st_q;

    generate
        if (STAGES > 1) begin : g_multi
            always_comb begin
                st_d       = st_q;
                st_d.chain = {st_q.chain[STAGES-2:0], pin_in};
            end
        end else begin : g_single
            always_comb begin
                st_d       = st_q;
                st_d.chain = pin_in;
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.chain <= {STAGES{IDLE_LEVEL}};
        end else begin
            st_q <= st_d;
        end
    end

    assign pin_sync = st_q.chain[STAGES-1];

endmodule

// File: rtl/bce_decode.sv
module bce_decode
    import bce_pkg::*;
#(
    parameter int         OP_W        = 8,
    parameter logic [3:0] PLAIN_ROW   = 4'h2,
    parameter logic [3:0] SIGNED_ROW  = 4'h9,
    parameter int         SIGNED_CNT  = 2
) (
    input  logic [OP_W-1:0] opcode,
    output bce_decode_t     dec
);

    localparam int ROW_LSB = OP_W - 4;

    logic [3:0] row_bits;
    logic [2:0] sel_bits;

    assign row_bits = opcode[OP_W-1:ROW_LSB];
    assign sel_bits = opcode[3:1];

    always_comb begin
        dec.sel     = bce_sel_t'(sel_bits);
        dec.invert  = opcode[0];
        dec.row     = ROW_NONE;
        dec.illegal = 1'b1;
        if (row_bits == PLAIN_ROW) begin
            dec.row     = ROW_PLAIN;
            dec.illegal = 1'b0;
        end else if (row_bits == SIGNED_ROW && int'(sel_bits) < SIGNED_CNT) begin
            dec.row     = ROW_SIGNED;
            dec.illegal = 1'b0;
        end
    end

endmodule

// File: rtl/bce_cond_eval.sv
module bce_cond_eval
    import bce_pkg::*;
(
    input  bce_decode_t dec,
    input  bce_flags_t  flags,
    input  logic        pin_asserted,
    output logic        taken
);

    localparam int NUM_PLAIN  = 8;
    localparam int NUM_SIGNED = 2;

    logic [NUM_PLAIN-1:0]  plain_cond;
    logic [NUM_SIGNED-1:0] signed_cond;
    logic                  sign_agree;
    logic                  raw_cond;

    assign sign_agree = ~(flags.n ^ flags.v);

    always_comb begin
        plain_cond[SEL_ALWAYS]   = 1'b1;
        plain_cond[SEL_ABOVE]    = ~(flags.c | flags.z);
        plain_cond[SEL_NOCARRY]  = ~flags.c;
        plain_cond[SEL_NONZERO]  = ~flags.z;
        plain_cond[SEL_NOHALF]   = ~flags.h;
        plain_cond[SEL_POSITIVE] = ~flags.n;
        plain_cond[SEL_UNMASKED] = ~flags.i;
        plain_cond[SEL_PINLOW]   = pin_asserted;
        signed_cond[0]           = sign_agree;
        signed_cond[1]           = sign_agree & ~flags.z;
    end

    always_comb begin
        case (dec.row)
            ROW_PLAIN:  raw_cond = plain_cond[dec.sel];
            ROW_SIGNED: raw_cond = signed_cond[dec.sel[0]];
            default:    raw_cond = 1'b0;
        endcase
        taken = dec.illegal ? 1'b0 : (raw_cond ^ dec.invert);
    end

endmodule

// File: rtl/bce_target_adder.sv
module bce_target_adder #(
    parameter int ADDR_W = 16,
    parameter int DISP_W = 8
) (
    input  logic [ADDR_W-1:0] next_addr,
    input  logic [DISP_W-1:0] disp,
    input  logic              take,
    output logic [ADDR_W-1:0] target
);

    localparam int EXT_W = ADDR_W - DISP_W;

    logic [ADDR_W-1:0] disp_ext;
    logic [ADDR_W-1:0] branch_sum;

    assign disp_ext   = {{EXT_W{disp[DISP_W-1]}}, disp};
    assign branch_sum = next_addr + disp_ext;
    assign target     = take ? branch_sum : next_addr;

endmodule

// File: rtl/branch_cond_eval.sv
module branch_cond_eval
    import bce_pkg::*;
#(
    parameter int OP_W        = 8,
    parameter int ADDR_W      = 16,
    parameter int DISP_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OP_W-1:0]   opcode,
    input  logic              flag_c,
    input  logic              flag_z,
    input  logic              flag_n,
    input  logic              flag_v,
    input  logic              flag_h,
    input  logic              flag_i,
    input  logic              irq_pin_n,
    input  logic [ADDR_W-1:0] next_addr,
    input  logic [DISP_W-1:0] disp,
    output logic              taken,
    output logic [ADDR_W-1:0] target_pc,
    output logic              illegal
);

    bce_decode_t dec;
    bce_flags_t  flags;
    logic        pin_level_sync;
    logic        pin_asserted;
    logic        take_w;

    assign flags = '{c: flag_c, z: flag_z, n: flag_n, v: flag_v, h: flag_h, i: flag_i};

    bce_pin_sync #(
        .STAGES     (SYNC_STAGES),
        .IDLE_LEVEL (1'b1)
    ) pin_sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   (irq_pin_n),
        .pin_sync (pin_level_sync)
    );

    assign pin_asserted = ~pin_level_sync;

    bce_decode #(
        .OP_W (OP_W)
    ) decode_i (
        .opcode (opcode),
        .dec    (dec)
    );

    bce_cond_eval cond_i (
        .dec          (dec),
        .flags        (flags),
        .pin_asserted (pin_asserted),
        .taken        (take_w)
    );

    bce_target_adder #(
        .ADDR_W (ADDR_W),
        .DISP_W (DISP_W)
    ) adder_i (
        .next_addr (next_addr),
        .disp      (disp),
        .take      (take_w),
        .target    (target_pc)
    );

    assign taken   = take_w;
    assign illegal = dec.illegal;

endmodule

// File: rtl/bce_checker.sv
module bce_checker #(
    parameter int OP_W        = 8,
    parameter int ADDR_W      = 16,
    parameter int DISP_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [OP_W-1:0]   opcode,
    input logic              flag_n,
    input logic              flag_v,
    input logic              irq_pin_n,
    input logic [ADDR_W-1:0] next_addr,
    input logic [DISP_W-1:0] disp,
    input logic              taken,
    input logic [ADDR_W-1:0] target_pc,
    input logic              illegal
);

    localparam int EXT_W = ADDR_W - DISP_W;

    logic [1:0] since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rst <= 2'd0;
        end else if (since_rst != 2'd3) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    assert_illegal_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!taken && target_pc == next_addr));

    assert_fallthrough_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !taken |-> target_pc == next_addr);

    assert_target_sum_R5: assert property (@(posedge clk) disable iff (!rst_n)
        taken |-> target_pc == next_addr + {{EXT_W{disp[DISP_W-1]}}, disp});

    assert_always_R1: assert property (@(posedge clk) disable iff (!rst_n)
        opcode == 8'h20 |-> taken);

    assert_never_R3: assert property (@(posedge clk) disable iff (!rst_n)
        opcode == 8'h21 |-> !taken);

    assert_signed_ge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == 8'h90 && flag_n == flag_v) |-> taken);

    generate
        if (SYNC_STAGES == 2) begin : g_pin_chk
            assert_pin_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (since_rst >= 2'd2 && opcode == 8'h2E && $past(irq_pin_n, 2) == 1'b0) |-> taken);
        end
    endgenerate

endmodule

bind branch_cond_eval bce_checker #(
    .OP_W        (OP_W),
    .ADDR_W      (ADDR_W),
    .DISP_W      (DISP_W),
    .SYNC_STAGES (SYNC_STAGES)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .opcode    (opcode),
    .flag_n    (flag_n),
    .flag_v    (flag_v),
    .irq_pin_n (irq_pin_n),
    .next_addr (next_addr),
    .disp      (disp),
    .taken     (taken),
    .target_pc (target_pc),
    .illegal   (illegal)
);

// File: tb/branch_cond_eval_tb.sv
module branch_cond_eval_tb_top;

    logic        clk;
    logic        rst_n;
    logic [7:0]  opcode;
    logic        flag_c, flag_z, flag_n, flag_v, flag_h, flag_i;
    logic        irq_pin_n;
    logic [15:0] next_addr;
    logic [7:0]  disp;
    logic        taken;
    logic [15:0] target_pc;
    logic        illegal;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    branch_cond_eval dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .opcode    (opcode),
        .flag_c    (flag_c),
        .flag_z    (flag_z),
        .flag_n    (flag_n),
        .flag_v    (flag_v),
        .flag_h    (flag_h),
        .flag_i    (flag_i),
        .irq_pin_n (irq_pin_n),
        .next_addr (next_addr),
        .disp      (disp),
        .taken     (taken),
        .target_pc (target_pc),
        .illegal   (illegal)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    // flag vector order: {c,z,n,v,h,i}
    function automatic bit ref_illegal(input logic [7:0] op);
        return !((op[7:4] == 4'h2) || (op[7:4] == 4'h9 && op[3:2] == 2'b00));
    endfunction

    function automatic bit ref_taken(input logic [7:0] op, input logic [5:0] f, input bit pin_low);
        bit c, z, n, v, h, i, cond;
        c = f[5]; z = f[4]; n = f[3]; v = f[2]; h = f[1]; i = f[0];
        if (ref_illegal(op)) return 1'b0;
        if (op[7:4] == 4'h2) begin
            case (op[3:1])
                3'd0: cond = 1'b1;
                3'd1: cond = !c && !z;
                3'd2: cond = !c;
                3'd3: cond = !z;
                3'd4: cond = !h;
                3'd5: cond = !n;
                3'd6: cond = !i;
                default: cond = pin_low;
            endcase
        end else begin
            cond = (op[1] == 1'b0) ? (n == v) : (!z && (n == v));
        end
        return cond ^ op[0];
    endfunction

    function automatic logic [15:0] ref_target(input logic [15:0] na, input logic [7:0] d, input bit tk);
        return tk ? 16'(na + {{8{d[7]}}, d}) : na;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s op=%02h actual=%0h expected=%0h", req, opcode, act, exp);
        end
    endtask

    task automatic set_flags(input logic [5:0] f);
        {flag_c, flag_z, flag_n, flag_v, flag_h, flag_i} = f;
    endtask

    function automatic string tag_for(input logic [7:0] op);
        if (ref_illegal(op)) return "R4";
        if (op[7:1] == 7'h17) return "R7";
        if (op[0]) return "R3";
        if (op[7:4] == 4'h9) return "R2";
        return "R1";
    endfunction

    task automatic sweep(input bit pin_low);
        for (int op = 0; op < 256; op++) begin
            for (int f = 0; f < 64; f++) begin
                bit tk;
                opcode    = 8'(op);
                set_flags(6'(f));
                next_addr = 16'($urandom);
                disp      = 8'($urandom);
                #1;
                tk = ref_taken(opcode, 6'(f), pin_low);
                check(tag_for(opcode), {31'd0, taken}, {31'd0, tk});
                check("R4 illegal flag", {31'd0, illegal}, {31'd0, ref_illegal(opcode)});
                check(tk ? "R5 target" : "R6 fallthrough", {16'd0, target_pc},
                      {16'd0, ref_target(next_addr, disp, tk)});
            end
        end
    endtask

    task automatic wrap_case(input logic [15:0] na, input logic [7:0] d, input logic [15:0] exp);
        opcode = 8'h20; next_addr = na; disp = d; #1;
        check("R5 wrap", {16'd0, target_pc}, {16'd0, exp});
        opcode = 8'h21; #1;
        check("R6 not taken", {16'd0, target_pc}, {16'd0, na});
    endtask

    initial begin
        #(5ns * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog R8 actual=timeout expected=complete");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0; irq_pin_n = 1'b0; opcode = 8'h2E; set_flags(6'd0);
        next_addr = 16'h1000; disp = 8'h10;
        repeat (4) @(posedge clk);
        @(negedge clk); #1;
        // reset: synchronizer idles deasserted even with pin held low
        check("R7 reset idle", {31'd0, taken}, 32'd0);
        check("R6 reset target", {16'd0, target_pc}, 32'h1000);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        check("R7 one edge", {31'd0, taken}, 32'd0);
        @(posedge clk); #1;
        check("R7 two edges", {31'd0, taken}, 32'd1);
        check("R5 pin target", {16'd0, target_pc}, 32'h1010);

        // R8: flags affect taken with no clock edge
        @(negedge clk);
        opcode = 8'h24; set_flags(6'b000000); #0.5;
        check("R8 comb", {31'd0, taken}, 32'd1);
        flag_c = 1'b1; #0.5;
        check("R8 comb", {31'd0, taken}, 32'd0);

        // directed wrap corners
        @(negedge clk);
        wrap_case(16'hFFFF, 8'h01, 16'h0000);
        wrap_case(16'h0000, 8'h80, 16'hFF80);
        wrap_case(16'h7FF0, 8'h7F, 16'h806F);
        wrap_case(16'h0005, 8'hFB, 16'h0000);

        // exhaustive opcode x flags with pin asserted, then deasserted
        @(negedge clk);
        sweep(1'b1);
        @(negedge clk); irq_pin_n = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        sweep(1'b0);

        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule